// File: doc/BRIEF.md
# Keyed-restart watchdog timer

This block is a watchdog counter serviced by a processor over a small register bus. Software must regularly write one fixed key byte to a restart register; each correct key write clears the counter and begins a fresh timeout interval. If the counter reaches the end of its interval first, the block raises a one-clock overflow pulse that the system reset logic is expected to act on. The counter advances only on cycles where the tick input is high, so the timebase comes from outside.

A mode register selects the timeout period, or stops the watchdog. It accepts exactly one write after reset. Before that write the block already runs, using its longest period. Any misuse raises the overflow pulse on the very next clock: a restart write with the wrong byte, a single-bit access to the restart register, or a second write to the mode register. Once the watchdog has been stopped, all of these misuses are ignored. A read of the restart register always returns a fixed constant, which is not the key, so the key cannot be recovered by reading it back.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, ovf_o and bus_rdata are 0, and the block counts with the longest period of 2^(MIN_EXP+7) ticks until the mode register is written.
- R2: The counter advances only on clocks with tick high. On the clock after the tick that completes the period, ovf_o is high for exactly one cycle, and counting then starts again from zero.
- R3: The first write to address 0 (the mode register) clears the counter. Data 00h stops the watchdog. Any other byte runs it with a period of 2^(MIN_EXP+data[2:0]) ticks.
- R4: A word write (bus_bit low) of ACh to address 1 (the restart register) clears the counter and produces no overflow.
- R5: A word write of any value other than ACh to address 1, while the watchdog is not stopped, makes ovf_o high on the next clock and clears the counter.
- R6: A write to address 1 with bus_bit high, while the watchdog is not stopped, makes ovf_o high on the next clock whatever the data.
- R7: A second write to address 0, while the watchdog is not stopped, makes ovf_o high on the next clock and clears the counter. The selected period stays unchanged.
- R8: While the watchdog is stopped, it does not count and ovf_o stays low, even after wrong keys, single-bit accesses or further mode writes.
- R9: On the clock after a read strobe, bus_rdata holds 9Ah for address 1, the mode byte for address 0 (07h before the first write), and 00h for any other address or when no read occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable for the timeout counter |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_bit | input | 1 | Marks the access as a single-bit access |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_o | output | 1 | Overflow pulse, one clock wide |

## Verification
The assertions assume single-cycle strobes and a bus_addr, bus_bit and bus_wdata that are stable and known whenever a strobe is high. They also assume that a read and a write are never requested in the same cycle. The bench drives every access from a task that raises the strobe for one full cycle, holds the data with it, and keeps tick low during bus accesses. As a result, each measured period counts only the ticks the bench issued itself. Because the stopped state lasts until reset, the bench resets the block between scenarios.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] KICK_KEY  = 8'hAC;
  localparam logic [7:0] KICK_READ = 8'h9A;
  localparam logic [7:0] MODE_RST  = 8'h07;

  typedef struct packed {
    logic mode_wr;
    logic kick_ok;
    logic kick_bad;
  } bus_ev_t;
endpackage

// File: rtl/wdt_bus_dec.sv
module wdt_bus_dec
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 0,
  parameter int KICK_ADDR = 1
) (
  input  logic              bus_wr,
  input  logic              bus_bit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output bus_ev_t           ev
);
  logic hit_mode, hit_kick;

  always_comb begin
    hit_mode    = bus_wr && (bus_addr == ADDR_W'(MODE_ADDR));
    hit_kick    = bus_wr && (bus_addr == ADDR_W'(KICK_ADDR));
    ev.mode_wr  = hit_mode;
    ev.kick_ok  = hit_kick && !bus_bit && (bus_wdata == KICK_KEY);
    ev.kick_bad = hit_kick && (bus_bit || (bus_wdata != KICK_KEY));
  end
endmodule

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
  import wdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [7:0]       wdata,
  output logic             stopped,
  output logic             written,
  output logic [SEL_W-1:0] sel,
  output logic [7:0]       mode_byte,
  output logic             mode_fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stopped   <= 1'b0;
      written   <= 1'b0;
      mode_byte <= MODE_RST;
    end else if (mode_wr && !written) begin
      written   <= 1'b1;
      stopped   <= (wdata == 8'h00);
      mode_byte <= wdata;
    end
  end

  assign sel        = mode_byte[SEL_W-1:0];
  assign mode_fault = mode_wr && written && !stopped;
endmodule

// File: rtl/wdt_ctr.sv
module wdt_ctr #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             terminal
);
  localparam logic [SEL_W-1:0] MAX_SEL = '1;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit    = {CNT_W{1'b1}} >> (MAX_SEL - sel);
    terminal = run && tick && !clear && (cnt == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || terminal) cnt <= '0;
    else if (run && tick)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 0,
  parameter int KICK_ADDR = 1,
  parameter int SEL_W     = 3,
  parameter int MIN_EXP   = 13,
  localparam int CNT_W    = MIN_EXP + (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_bit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              ovf_o
);
  bus_ev_t          ev;
  logic             stopped_w, written_w, mode_fault, kick_fault, terminal;
  logic [SEL_W-1:0] sel;
  logic [7:0]       mode_byte;
  logic [CNT_W-1:0] cnt;
  logic             fault, clear;

  wdt_bus_dec #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR)) dec_i (
    .bus_wr(bus_wr), .bus_bit(bus_bit), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ev(ev)
  );

  wdt_mode_ctl #(.SEL_W(SEL_W)) mode_i (
    .clk(clk), .rst(rst), .mode_wr(ev.mode_wr), .wdata(bus_wdata),
    .stopped(stopped_w), .written(written_w), .sel(sel),
    .mode_byte(mode_byte), .mode_fault(mode_fault)
  );

  assign kick_fault = ev.kick_bad && !stopped_w;
  assign fault      = mode_fault || kick_fault;
  assign clear      = fault || ev.kick_ok || ev.mode_wr;

  wdt_ctr #(.SEL_W(SEL_W), .CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst(rst), .run(!stopped_w), .tick(tick), .clear(clear),
    .sel(sel), .cnt(cnt), .terminal(terminal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o     <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      ovf_o <= fault || terminal;
      if (bus_rd && bus_addr == ADDR_W'(KICK_ADDR))      bus_rdata <= KICK_READ;
      else if (bus_rd && bus_addr == ADDR_W'(MODE_ADDR)) bus_rdata <= mode_byte;
      else                                               bus_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int MODE_ADDR = 0,
  parameter int KICK_ADDR = 1,
  parameter int CNT_W     = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_bit,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              ovf_o,
  input logic              stopped,
  input logic              written,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  ovf_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt == '0));
  // R4
  good_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(KICK_ADDR) && !bus_bit && bus_wdata == KICK_KEY) |=> !ovf_o);
  // R5
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(KICK_ADDR) && !bus_bit && bus_wdata != KICK_KEY && !stopped) |=> ovf_o);
  // R6
  bit_access_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(KICK_ADDR) && bus_bit && !stopped) |=> ovf_o);
  // R7
  mode_twice_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(MODE_ADDR) && written && !stopped) |=> ovf_o);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    stopped |=> !ovf_o);
  // R9
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(KICK_ADDR)) |=> (bus_rdata == KICK_READ));
endmodule

bind wdt_keyed wdt_keyed_chk #(
  .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .KICK_ADDR(KICK_ADDR), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_bit(bus_bit),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ovf_o(ovf_o), .stopped(stopped_w), .written(written_w), .cnt(cnt)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_EXP    = 4;
  localparam int ADDR_W     = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0, bus_bit = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = 8'h00;
  logic [7:0]        bus_rdata;
  logic              ovf_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed #(.ADDR_W(ADDR_W), .MIN_EXP(MIN_EXP)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_bit(bus_bit), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input int addr, input logic [7:0] data, input bit bitacc);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data; bus_bit = bitacc;
    @(negedge clk);
    bus_wr = 1'b0; bus_bit = 1'b0;
  endtask

  task automatic bus_read(input int addr, output logic [7:0] data);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ADDR_W'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    data = bus_rdata;
  endtask

  // issues ticks until ovf_o is seen or max ticks were given
  task automatic run_ticks(input int max, output int n);
    n = 0;
    while (n < max) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      #1;
      n++;
      if (ovf_o) break;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check(ovf_o == 1'b0, "R1 ovf after reset", ovf_o, 0);
    check(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 0);
    bus_read(0, d);
    check(d == 8'h07, "R9 mode reset value", d, 7);
    bus_read(1, d);
    check(d == 8'h9A, "R9 restart readback", d, 'h9A);
    bus_read(5, d);
    check(d == 8'h00, "R9 unmapped read", d, 0);
  endtask

  task automatic t_default_period();
    int n;
    do_reset();
    run_ticks(5000, n);
    check(n == 2048, "R1 default period", n, 2048);
    @(posedge clk); #1;
    check(ovf_o == 1'b0, "R2 single-cycle pulse", ovf_o, 0);
    run_ticks(5000, n);
    check(n == 2048, "R2 restart after overflow", n, 2048);
  endtask

  task automatic t_mode_and_gate();
    int n;
    logic [7:0] d;
    do_reset();
    run_ticks(100, n);
    bus_write(0, 8'h09, 1'b0);
    check(ovf_o == 1'b0, "R3 first mode write", ovf_o, 0);
    bus_read(0, d);
    check(d == 8'h09, "R9 mode readback", d, 9);
    repeat (100) begin
      @(posedge clk); #1;
      if (ovf_o) check(1'b0, "R2 no count without tick", 1, 0);
    end
    run_ticks(5000, n);
    check(n == 32, "R3 selected period", n, 32);
  endtask

  task automatic t_key_restart();
    int n;
    do_reset();
    bus_write(0, 8'h01, 1'b0);
    run_ticks(20, n);
    bus_write(1, 8'hAC, 1'b0);
    check(ovf_o == 1'b0, "R4 good key no overflow", ovf_o, 0);
    run_ticks(5000, n);
    check(n == 32, "R4 key restarts interval", n, 32);
  endtask

  task automatic t_faults();
    int n;
    do_reset();
    bus_write(0, 8'h01, 1'b0);
    run_ticks(10, n);
    bus_write(1, 8'h55, 1'b0);
    check(ovf_o == 1'b1, "R5 wrong key overflow", ovf_o, 1);
    run_ticks(5000, n);
    check(n == 32, "R5 counter cleared", n, 32);
    bus_write(1, 8'hAC, 1'b1);
    check(ovf_o == 1'b1, "R6 bit access overflow", ovf_o, 1);
    run_ticks(10, n);
    bus_write(0, 8'h00, 1'b0);
    check(ovf_o == 1'b1, "R7 second mode write overflow", ovf_o, 1);
    run_ticks(5000, n);
    check(n == 32, "R7 period unchanged", n, 32);
  endtask

  task automatic t_stopped();
    int n;
    do_reset();
    bus_write(0, 8'h00, 1'b0);
    run_ticks(3000, n);
    check(n == 3000, "R8 stopped no timeout", n, 3000);
    bus_write(1, 8'h12, 1'b0);
    check(ovf_o == 1'b0, "R8 wrong key ignored", ovf_o, 0);
    bus_write(1, 8'hAC, 1'b1);
    check(ovf_o == 1'b0, "R8 bit access ignored", ovf_o, 0);
    bus_write(0, 8'h03, 1'b0);
    check(ovf_o == 1'b0, "R8 mode rewrite ignored", ovf_o, 0);
    run_ticks(3000, n);
    check(n == 3000, "R8 still stopped", n, 3000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_default_period();
        t_mode_and_gate();
        t_key_restart();
        t_faults();
        t_stopped();
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule